// File: doc/BRIEF.md
# Index Register Address Unit

This block holds a small file of index registers and turns a decoded micro-operation into an operand effective address. The address is an immediate displacement combined with one or two selected index registers. The two registers can be added together, merged with a bitwise OR, or combined with the second register scaled by 1, 2, 4 or 8. A per-operation subtract bit takes the combined index term away from the displacement instead of adding it.

The same register file serves two more operations. Load-index writes an immediate into a register. Loop-step tests a register: when it is non-zero, the register is reduced by the immediate step and the block flags a taken branch. When it is zero, the loop falls through. On a loop-step the displacement is passed through as the loop-start target. Every result appears on registered outputs one cycle after the operation is presented with `valid` high.

Top module: `idx_addr_unit`

## Requirements
- R1: While reset is held, and after it is released, `out_valid`, `br_taken`, `ea` and `rd_data` are 0, and every index register holds 0.
- R2: Op code 1 (indexed add) gives `ea = disp + X[sel_a] + X[sel_b]` modulo 2^16 on the cycle after the operation, with `out_valid` high.
- R3: When `sub` is 1 on op codes 1, 2 or 3, the combined index term is subtracted from `disp` instead of added, modulo 2^16.
- R4: Op code 2 (OR combine) gives `ea = disp + (X[sel_a] | X[sel_b])`.
- R5: Op code 3 (scaled) gives `ea = disp + X[sel_a] + (X[sel_b] << scale)`, where scale code 0, 1, 2 and 3 means a factor of 1, 2, 4 and 8.
- R6: In op code 3, selecting register 7 (the stack slot) as `sel_b` contributes no scaled term.
- R7: Register 0 always reads as zero, and writes aimed at it are dropped.
- R8: Op code 4 (load-index) writes `imm` into `X[sel_a]` at the clock edge. `rd_data` reports the value the register held before the write. For op codes 0 to 4, `ea = disp` except where R2 to R5 say otherwise.
- R9: Op code 5 (loop-step) on a non-zero `X[sel_a]` writes `X[sel_a] - imm`, raises `br_taken` for one cycle and sets `ea = disp`. For example, loading 400 and stepping by 4 takes the branch exactly 100 times.
- R10: Op code 5 on a zero `X[sel_a]` leaves the register unchanged, keeps `br_taken` low and still sets `ea = disp`.
- R11: With `valid` low, no register changes, `out_valid` and `br_taken` are 0, and `ea` and `rd_data` hold their previous values. Op codes 0, 6 and 7 change no register and never raise `br_taken`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Qualifies the operation in this cycle |
| op | input | 3 | Operation code (0 none, 1 add, 2 OR, 3 scaled, 4 load, 5 loop) |
| sel_a | input | 3 | First index register select, and target of load and loop |
| sel_b | input | 3 | Second index register select |
| scale | input | 2 | Scale code for the second index (factor 2^scale) |
| sub | input | 1 | Subtract the index term from the displacement |
| disp | input | 16 | Displacement, also the loop-start target |
| imm | input | 16 | Load value or loop step |
| out_valid | output | 1 | Result registers updated by a valid operation |
| ea | output | 16 | Effective address |
| br_taken | output | 1 | Loop-step branch taken |
| rd_data | output | 16 | Value of X[sel_a] before the operation |

## Verification
Seeded random operations run against a reference register file in the bench. The random mix covers all op codes, both sub settings, every scale code and idle cycles. It tells the add, OR and scaled combines apart, because random register contents give different sums for each. Directed cases cover the separate corner cases: the stack slot as the scaled index, writes to register 0, a read of a register in the same cycle as a write to it, and a 400-by-4 loop. The loop checks that the branch is taken exactly 100 times and then falls through.

// File: rtl/idx_addr_unit.sv
module idx_addr_unit #(
  parameter int AW = 16,
  parameter int NREG = 8,
  parameter int SP_SEL = NREG - 1,
  localparam int SW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [2:0]    op,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_b,
  input  logic [1:0]    scale,
  input  logic          sub,
  input  logic [AW-1:0] disp,
  input  logic [AW-1:0] imm,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic          br_taken,
  output logic [AW-1:0] rd_data
);
  localparam logic [2:0] OP_ADD  = 3'd1;
  localparam logic [2:0] OP_OR   = 3'd2;
  localparam logic [2:0] OP_SCL  = 3'd3;
  localparam logic [2:0] OP_LOAD = 3'd4;
  localparam logic [2:0] OP_LOOP = 3'd5;

  logic [AW-1:0] xr [NREG];
  logic [AW-1:0] va, vb, term, ea_n;

  assign va = (sel_a == '0) ? '0 : xr[sel_a];
  assign vb = (sel_b == '0) ? '0 : xr[sel_b];

  always_comb begin
    case (op)
      OP_ADD:  term = va + vb;
      OP_OR:   term = va | vb;
      OP_SCL:  term = va + ((sel_b == SW'(SP_SEL)) ? '0 : (vb << scale));
      default: term = '0;
    endcase
    ea_n = sub && (op == OP_ADD || op == OP_OR || op == OP_SCL) ? disp - term : disp + term;
  end

  wire take = valid && op == OP_LOOP && va != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) xr[i] <= '0;
      out_valid <= 1'b0;
      br_taken  <= 1'b0;
      ea        <= '0;
      rd_data   <= '0;
    end else begin
      out_valid <= valid;
      br_taken  <= take;
      if (valid) begin
        ea      <= ea_n;
        rd_data <= va;
        if (op == OP_LOAD && sel_a != '0) xr[sel_a] <= imm;
        if (take) xr[sel_a] <= va - imm;
      end
    end
  end
endmodule

module idx_addr_unit_chk #(
  parameter int AW = 16,
  parameter int NREG = 8,
  parameter int SP_SEL = NREG - 1,
  localparam int SW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid,
  input logic [2:0]    op,
  input logic [SW-1:0] sel_a,
  input logic [SW-1:0] sel_b,
  input logic          sub,
  input logic [AW-1:0] disp,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic          br_taken,
  input logic [AW-1:0] rd_data
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> (!out_valid && !br_taken));

  // R11
  branch_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> out_valid);

  // R9 R10
  loop_branch_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 3'd5) |=> (br_taken == (rd_data != '0)) && ea == $past(disp));

  // R7
  zero_reg_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 3'd1 && sel_a == '0 && sel_b == '0) |=> (ea == $past(disp) && rd_data == '0));

  // R6
  stack_slot_scaled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == 3'd3 && sel_a == '0 && sel_b == SW'(SP_SEL)) |=> ea == $past(disp));

  // R11
  other_op_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op != 3'd5) |=> !br_taken);
endmodule

bind idx_addr_unit idx_addr_unit_chk #(.AW(AW), .NREG(NREG), .SP_SEL(SP_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .sel_a(sel_a), .sel_b(sel_b),
  .sub(sub), .disp(disp), .out_valid(out_valid), .ea(ea), .br_taken(br_taken),
  .rd_data(rd_data)
);

// File: tb/idx_addr_unit_bench.sv
module idx_addr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, sub = 1'b0;
  logic [2:0] op = '0, sel_a = '0, sel_b = '0;
  logic [1:0] scale = '0;
  logic [15:0] disp = '0, imm = '0;
  logic out_valid, br_taken;
  logic [15:0] ea, rd_data;

  idx_addr_unit u_idx_addr_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [15:0] m [8];
  logic [15:0] e_ea = '0, e_rd = '0;
  logic e_v = 1'b0, e_br = 1'b0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag(logic [2:0] o, logic s, logic [2:0] b);
    if (s && o >= 1 && o <= 3) return "R3";
    case (o)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return (b == 3'd7) ? "R6" : "R5";
      3'd4: return "R8";
      3'd5: return "R9/R10";
      default: return "R11";
    endcase
  endfunction

  // called at a negedge: drive, model, then check at the next negedge
  task automatic apply(logic v, logic [2:0] o, logic [2:0] a, logic [2:0] b,
                       logic [1:0] sc, logic s, logic [15:0] d, logic [15:0] im);
    logic [15:0] xa, xb, t;
    string r;
    valid = v; op = o; sel_a = a; sel_b = b; scale = sc; sub = s; disp = d; imm = im;
    xa = m[a]; xb = m[b];
    case (o)
      3'd1: t = xa + xb;
      3'd2: t = xa | xb;
      3'd3: t = xa + ((b == 3'd7) ? 16'd0 : 16'(xb << sc));
      default: t = 16'd0;
    endcase
    e_v = v;
    e_br = v && o == 3'd5 && xa != 0;
    if (v) begin
      e_ea = (s && o >= 1 && o <= 3) ? d - t : d + t;
      e_rd = xa;
      if (o == 3'd4 && a != 0) m[a] = im;
      if (e_br) m[a] = xa - im;
    end
    r = v ? tag(o, s, b) : "R11";
    @(negedge clk);
    chk({r, " out_valid"}, 16'(out_valid), 16'(e_v));
    chk({r, " br_taken"}, 16'(br_taken), 16'(e_br));
    chk({r, " ea"}, ea, e_ea);
    chk({r, " rd_data"}, rd_data, e_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int taken;
    void'($urandom(32'h1d5e));
    for (int i = 0; i < 8; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1 out_valid", 16'(out_valid), 16'd0);
    chk("R1 br_taken", 16'(br_taken), 16'd0);
    chk("R1 ea", ea, 16'd0);
    chk("R1 rd_data", rd_data, 16'd0);
    rst_n = 1'b1;
    // R1 registers start at zero
    for (int i = 0; i < 8; i++) apply(1, 3'd1, 3'(i), 3'd0, 0, 0, 16'd0, 16'd0);
    // R7 register 0 write dropped
    apply(1, 3'd4, 3'd0, 3'd0, 0, 0, 16'h1111, 16'hbeef);
    apply(1, 3'd1, 3'd0, 3'd0, 0, 0, 16'h0010, 16'd0);
    // R8 load then read-before-write
    apply(1, 3'd4, 3'd7, 3'd0, 0, 0, 16'd0, 16'h0100);
    apply(1, 3'd4, 3'd3, 3'd0, 0, 0, 16'd0, 16'h0020);
    apply(1, 3'd4, 3'd3, 3'd0, 0, 0, 16'd0, 16'h0030);
    // R6 stack slot gives no scaled term, R5 otherwise
    apply(1, 3'd3, 3'd3, 3'd7, 2'd3, 0, 16'h1000, 16'd0);
    apply(1, 3'd3, 3'd3, 3'd3, 2'd3, 0, 16'h1000, 16'd0);
    // R3 subtract
    apply(1, 3'd3, 3'd3, 3'd7, 2'd1, 1, 16'h0000, 16'd0);
    // R11 idle leaves registers alone
    apply(0, 3'd4, 3'd3, 3'd0, 0, 0, 16'h5555, 16'hffff);
    apply(1, 3'd1, 3'd3, 3'd0, 0, 0, 16'd0, 16'd0);
    // R9 R10 loop walk: 400 by 4
    apply(1, 3'd4, 3'd2, 3'd0, 0, 0, 16'd0, 16'd400);
    taken = 0;
    for (int k = 0; k < 110; k++) begin
      apply(1, 3'd5, 3'd2, 3'd0, 0, 0, 16'h0040, 16'd4);
      if (br_taken) taken++;
    end
    chk("R9 loop count", 16'(taken), 16'd100);
    chk("R10 reg after fall-through", m[2], 16'd0);
    apply(1, 3'd1, 3'd2, 3'd0, 0, 0, 16'd0, 16'd0);
    // random mix
    for (int k = 0; k < 3000; k++)
      apply(($urandom % 8) != 0, 3'($urandom), 3'($urandom), 3'($urandom),
            2'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule